// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Loader

This block is the digital front end of a two-channel 16-bit converter. A host drives a parallel bus made of a data word, a two-bit channel address and an active-low write strobe. When the strobe is released, the word goes into the holding register of the addressed channel, or into both holding registers at once. The converter outputs come from a second stage of registers. That stage takes the holding values only while an active-low load control is held low, so both channels can change in the same clock cycle.

A clear input and a power-on hold after system reset force every register in both stages to one code. A select pin picks that code: zero scale (0x0000) or midscale (0x8000). The clock samples all control pins through two-stage synchronisers. The bus is delayed by the same number of stages, so the word and address that are stored are the values present while the strobe was still low.

Top module: `dual_dac_loader`

## Requirements
- R1: While `rst_ni` is low both outputs read 0x0000. After its release a power-on hold of 8 cycles loads every register with the reset code, which is 0x0000 when `mid_sel_i` is 0 and 0x8000 when it is 1. Both outputs show that code once the hold ends.
- R2: A write with address 2'b00 loads channel A's holding register only.
- R3: A write with address 2'b01 loads channel B's holding register only.
- R4: A write with address 2'b11 loads the same word into both holding registers.
- R5: A write with address 2'b10 changes no register.
- R6: While `load_ni` is high both outputs hold their value, even across writes.
- R7: While `load_ni` is low both output registers follow their holding registers, and both channels update in the same cycle.
- R8: A low on `clr_ni` with `mid_sel_i` at 0 sets both holding and both output registers to 0x0000.
- R9: A low on `clr_ni` with `mid_sel_i` at 1 sets all four registers to 0x8000.
- R10: While a clear is active, writes and loads have no effect.
- R11: A write takes effect only when `wr_ni` rises. Holding the strobe low changes nothing, and the stored word is the bus value from while the strobe was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| data_i | input | 16 | Parallel data word |
| addr_i | input | 2 | Channel address for a write |
| wr_ni | input | 1 | Active-low write strobe; a write happens on its release |
| load_ni | input | 1 | Active-low level-sensitive load of the output registers |
| clr_ni | input | 1 | Active-low clear to the selected reset code |
| mid_sel_i | input | 1 | Reset code select: 0 gives zero scale, 1 gives midscale |
| dac_a_o | output | 16 | Channel A output register |
| dac_b_o | output | 16 | Channel B output register |

## Verification
The assertions check these rules on every cycle in each channel:
- Outputs stay fixed when neither a load nor a clear is active.
- Outputs track the holding register while a load is active.
- A clear forces both stages to the selected code.
- Holding registers change only on a write or a clear.
- The power-on hold ends and does not return.

The bench scenarios cover what a single-cycle property cannot:
- The address decode, including the ignored 2'b10 code and the dual-channel 2'b11 code.
- Capture on strobe release with the right data after the bus has moved on.
- The zero-scale and midscale codes on clear and at power-up.
- Clear beating a write and a load that overlap it.

// File: rtl/dacl_pkg.sv
package dacl_pkg;

  localparam int unsigned NUM_CH = 2;

  // Per-channel select from the bus address: bit 0 is channel A, bit 1 channel B.
  function automatic logic [NUM_CH-1:0] chan_hits(input logic [1:0] addr);
    logic [NUM_CH-1:0] hit;
    unique case (addr)
      2'b00:   hit = 2'b01;
      2'b01:   hit = 2'b10;
      2'b11:   hit = 2'b11;
      default: hit = 2'b00;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/dacl_rst_sync.sv
module dacl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/dacl_sync.sv
module dacl_sync #(
  parameter int unsigned         WIDTH     = 1,
  parameter int unsigned         STAGES    = 2,
  parameter logic [WIDTH-1:0]    RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = din;
    for (int i = 1; i < int'(STAGES); i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= {STAGES{RESET_VAL}};
    else         stage_q <= stage_d;
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/dacl_por.sv
module dacl_por #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk,
  input  logic rst_ni,
  output logic busy_o
);

  localparam int unsigned   CW   = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          busy;

  assign busy = (cnt_q != LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (busy) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign busy_o = busy;

  // R1: once the power-on hold ends it never comes back without a reset
  p_por_sticky_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy_o |=> !busy_o);

endmodule

// File: rtl/dacl_chan.sv
module dacl_chan #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              clear,
  input  logic [DATA_W-1:0] code,
  input  logic              we,
  input  logic [DATA_W-1:0] din,
  input  logic              load,
  output logic [DATA_W-1:0] dac_o
);

  logic [DATA_W-1:0] hold_q, hold_d;
  logic [DATA_W-1:0] dac_q,  dac_d;

  always_comb begin
    hold_d = hold_q;
    if (clear)   hold_d = code;
    else if (we) hold_d = din;
  end

  always_comb begin
    dac_d = dac_q;
    if (clear)     dac_d = code;
    else if (load) dac_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      dac_q  <= '0;
    end else begin
      hold_q <= hold_d;
      dac_q  <= dac_d;
    end
  end

  assign dac_o = dac_q;

  // R6: output holds without load or clear
  p_dac_hold_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clear && !load) |=> $stable(dac_o));

  // R7: output follows the holding register during load
  p_dac_follow_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clear && load) |=> (dac_o == $past(hold_q)));

  // R8 / R9 / R10: clear wins and sets both stages to the code
  p_clear_code_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    clear |=> (dac_o == $past(code) && hold_q == $past(code)));

  // R5: holding register changes only on write or clear
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clear && !we) |=> $stable(hold_q));

endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned POR_CYCLES  = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_ni,
  input  logic              load_ni,
  input  logic              clr_ni,
  input  logic              mid_sel_i,
  output logic [DATA_W-1:0] dac_a_o,
  output logic [DATA_W-1:0] dac_b_o
);

  import dacl_pkg::*;

  localparam int unsigned       BUS_W = DATA_W + 2;
  localparam logic [DATA_W-1:0] MID   = {1'b1, {(DATA_W-1){1'b0}}};

  logic rst_n_int;

  dacl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  // Control pins: wr, load, clr, mid_sel (strobes idle high)
  logic [3:0] ctl_s;
  dacl_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RESET_VAL(4'b0111)) u_ctl_sync (
    .clk    (clk),
    .rst_ni (rst_n_int),
    .din    ({mid_sel_i, clr_ni, load_ni, wr_ni}),
    .dout   (ctl_s)
  );

  // Bus delayed by the same depth so it lines up with the strobe
  logic [BUS_W-1:0] bus_s;
  dacl_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) u_bus_dly (
    .clk    (clk),
    .rst_ni (rst_n_int),
    .din    ({addr_i, data_i}),
    .dout   (bus_s)
  );

  logic wr_s, load_s, clr_s, mid_s;
  assign wr_s   = ctl_s[0];
  assign load_s = ~ctl_s[1];
  assign clr_s  = ~ctl_s[2];
  assign mid_s  = ctl_s[3];

  logic             wr_prev_q, wr_prev_d;
  logic [BUS_W-1:0] bus_prev_q, bus_prev_d;

  always_comb begin
    wr_prev_d  = wr_s;
    bus_prev_d = bus_s;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      wr_prev_q  <= 1'b1;
      bus_prev_q <= '0;
    end else begin
      wr_prev_q  <= wr_prev_d;
      bus_prev_q <= bus_prev_d;
    end
  end

  logic              wr_edge;
  logic [1:0]        wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [NUM_CH-1:0] hits;

  assign wr_edge = wr_s & ~wr_prev_q;
  assign wr_addr = bus_prev_q[BUS_W-1 -: 2];
  assign wr_data = bus_prev_q[DATA_W-1:0];
  assign hits    = chan_hits(wr_addr);

  logic por_busy;
  dacl_por #(.CYCLES(POR_CYCLES)) u_por (
    .clk    (clk),
    .rst_ni (rst_n_int),
    .busy_o (por_busy)
  );

  logic              clear;
  logic [DATA_W-1:0] code;
  assign clear = clr_s | por_busy;
  assign code  = mid_s ? MID : '0;

  logic [NUM_CH-1:0][DATA_W-1:0] dac_bus;

  for (genvar ch = 0; ch < int'(NUM_CH); ch++) begin : g_chan
    dacl_chan #(.DATA_W(DATA_W)) u_chan (
      .clk    (clk),
      .rst_ni (rst_n_int),
      .clear  (clear),
      .code   (code),
      .we     (wr_edge & hits[ch]),
      .din    (wr_data),
      .load   (load_s),
      .dac_o  (dac_bus[ch])
    );
  end

  assign dac_a_o = dac_bus[0];
  assign dac_b_o = dac_bus[1];

  // R11: a write edge is a single-cycle event
  p_edge_single_r11: assert property (@(posedge clk) disable iff (!rst_n_int)
    wr_edge |=> !wr_edge);

endmodule

// File: tb/dual_dac_loader_tb.sv
module dual_dac_loader_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_data;
  logic [1:0]  bus_addr;
  logic        wr_n, ldac_n, clr_n, mid_sel;
  logic [15:0] dac_a, dac_b;

  int checks = 0;
  int fails  = 0;

  logic [15:0] exp_in  [2];
  logic [15:0] exp_dac [2];

  always #4 clk = ~clk;

  dual_dac_loader u_dut (
    .clk       (clk),
    .rst_ni    (rst_n),
    .data_i    (bus_data),
    .addr_i    (bus_addr),
    .wr_ni     (wr_n),
    .load_ni   (ldac_n),
    .clr_ni    (clr_n),
    .mid_sel_i (mid_sel),
    .dac_a_o   (dac_a),
    .dac_b_o   (dac_b)
  );

  function automatic logic f_hit(input logic [1:0] addr, input int ch);
    return (addr == 2'b11) || (addr == 2'(ch));
  endfunction

  function automatic logic [15:0] f_code(input logic mid);
    return mid ? 16'h8000 : 16'h0000;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk_both(input string tag);
    chk({tag, " chA"}, dac_a, exp_dac[0]);
    chk({tag, " chB"}, dac_b, exp_dac[1]);
  endtask

  task automatic do_write(input logic [1:0] addr, input logic [15:0] data, input int low_cycles);
    bus_addr = addr; bus_data = data; wr_n = 1'b0;
    cyc(low_cycles);
    wr_n = 1'b1;
    cyc(1);
    bus_data = 16'($urandom); bus_addr = 2'($urandom);
    cyc(6);
    for (int ch = 0; ch < 2; ch++) if (f_hit(addr, ch)) exp_in[ch] = data;
    if (!ldac_n) for (int ch = 0; ch < 2; ch++) exp_dac[ch] = exp_in[ch];
  endtask

  task automatic do_load();
    ldac_n = 1'b0; cyc(3); ldac_n = 1'b1; cyc(6);
    for (int ch = 0; ch < 2; ch++) exp_dac[ch] = exp_in[ch];
  endtask

  task automatic do_clear(input logic mid);
    mid_sel = mid; cyc(4);
    clr_n = 1'b0; cyc(3); clr_n = 1'b1; cyc(6);
    for (int ch = 0; ch < 2; ch++) begin
      exp_in[ch] = f_code(mid); exp_dac[ch] = f_code(mid);
    end
  endtask

  task automatic do_power_up(input logic mid);
    rst_n = 1'b0; mid_sel = mid; cyc(4);
    chk("R1 in reset A", dac_a, 16'h0000);
    chk("R1 in reset B", dac_b, 16'h0000);
    rst_n = 1'b1; cyc(16);
    for (int ch = 0; ch < 2; ch++) begin
      exp_in[ch] = f_code(mid); exp_dac[ch] = f_code(mid);
    end
    chk_both("R1 power-on code");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; bus_data = '0; bus_addr = '0;
    wr_n = 1'b1; ldac_n = 1'b1; clr_n = 1'b1; mid_sel = 1'b0;

    do_power_up(1'b0);
    do_power_up(1'b1);

    // R2 / R6: write A, output held until load
    do_write(2'b00, 16'h1234, 3);
    chk_both("R6 held after write");
    do_load();
    chk_both("R2 write A");

    // R3
    do_write(2'b01, 16'hBEEF, 3);
    do_load();
    chk_both("R3 write B");

    // R4
    do_write(2'b11, 16'h5A5A, 3);
    chk_both("R6 held after dual write");
    do_load();
    chk_both("R4 write both");

    // R5: address 10 ignored
    do_write(2'b10, 16'hFFFF, 3);
    do_load();
    chk_both("R5 addr 10 ignored");

    // R11 / R7: strobe held low with load transparent
    ldac_n = 1'b0; cyc(6);
    bus_addr = 2'b00; bus_data = 16'hC3C3; wr_n = 1'b0;
    cyc(10);
    chk_both("R11 no effect while strobe low");
    wr_n = 1'b1; cyc(1);
    bus_data = 16'h0F0F; bus_addr = 2'b11;
    cyc(6);
    exp_in[0] = 16'hC3C3; exp_dac[0] = 16'hC3C3;
    chk_both("R11 R7 captured on release");
    ldac_n = 1'b1; cyc(4);

    // R8 / R9
    do_clear(1'b0);
    chk_both("R8 zero clear outputs");
    do_load();
    chk_both("R8 zero clear holding regs");
    do_write(2'b11, 16'h7777, 3);
    do_load();
    do_clear(1'b1);
    chk_both("R9 mid clear outputs");
    do_load();
    chk_both("R9 mid clear holding regs");

    // R10: clear overlaps write and load
    mid_sel = 1'b0; cyc(4);
    clr_n = 1'b0; cyc(3);
    ldac_n = 1'b0;
    bus_addr = 2'b11; bus_data = 16'h4321; wr_n = 1'b0;
    cyc(3); wr_n = 1'b1; cyc(6);
    clr_n = 1'b1; ldac_n = 1'b1; cyc(6);
    for (int ch = 0; ch < 2; ch++) begin exp_in[ch] = 16'h0; exp_dac[ch] = 16'h0; end
    chk_both("R10 clear beats write and load");
    do_load();
    chk_both("R10 holding regs at code");

    // Random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op <= 5) begin
        logic [1:0] a;
        a = 2'($urandom);
        do_write(a, 16'($urandom), 2 + int'($urandom_range(0, 3)));
        chk_both(a == 2'b10 ? "R5 rnd" : (a == 2'b11 ? "R4 rnd" : (a == 2'b00 ? "R2 rnd" : "R3 rnd")));
      end else if (op <= 7) begin
        do_load();
        chk_both("R7 rnd load");
      end else if (op == 8) begin
        logic m;
        m = 1'($urandom);
        do_clear(m);
        chk_both(m ? "R9 rnd clear" : "R8 rnd clear");
      end else begin
        cyc(3);
        chk_both("R6 rnd idle");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule